// File: doc/BRIEF.md
# Dual Event and Free-Running Timer

This block gives a processor two independent time bases behind one 32-bit register port. The first is a 56-bit down-counter used to schedule events. Software stores a reload value, then writes a control word that can load the counter, enable it and choose between a single expiry and a repeating period. When the counter runs out, a sticky pending flag is set. An interrupt line reflects that flag, gated by a mask that software sets and clears through separate write-one registers.

The second is a 64-bit counter that never stops and serves as a monotonic clock. Software reads it as two 32-bit words, low word first. Reading the low word snapshots the upper half into a holding register, so the two halves always belong to the same instant. Both counters advance only in cycles where the tick-enable input is high, which lets a clock divider outside the block set the counting rate.

Top module: `dtmr_top`

## Requirements
- R1: After reset the interrupt output is 0, the mask (read at 0x02c bit 0) and the pending flag (read at 0x034 bit 0) are 0, the control word reads 0, and the free-running counter holds the FREE_INIT parameter value.
- R2: A write to the control word (0x004) with bit 30 set loads the counter with {control[23:0], reload low word at 0x000}; with bit 24 also set, a count of N (N >= 1) expires on the Nth tick after that write and sets the pending flag.
- R3: In single mode (control bit 28 = 0) the enable (control read bit 24) clears at expiry and no further expiry follows, however many ticks arrive.
- R4: In repeat mode (control bit 28 = 1) the counter reloads at expiry and expires again every N ticks, and the enable stays set.
- R5: Writing 0 to the control word stops the down-counter: later ticks cause no expiry.
- R6: Neither counter moves in a cycle where tick_en is 0.
- R7: Writing 1 to bit 0 at 0x02c sets the mask and writing 1 to bit 0 at 0x030 clears it; a write with bit 0 equal to 0 leaves the mask unchanged.
- R8: irq_out is high exactly while the pending flag and the mask are both 1.
- R9: Writing 1 to bit 0 at 0x034 clears the pending flag; a write there with bit 0 equal to 0 leaves it set.
- R10: When an expiry and an acknowledge write fall in the same cycle, the pending flag remains set.
- R11: The free-running counter increments by one on each tick; its low word reads at 0x024.
- R12: A read at 0x028 returns the upper word captured by the most recent read at 0x024, even if the counter has carried into the upper word since.
- R13: The reload value is a full 56 bits: 0x000 and control bits [23:0] read back as written, and a nonzero upper part lengthens the count beyond the low word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable pulse setting the counting rate |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe, used to snapshot the upper counter word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq_out | output | 1 | Level interrupt: pending and mask both set |

## Verification
The hardest situation to reach is a carry from the low to the high word of the free-running counter between the two halves of a split read, since from reset it needs four billion ticks. The bench instantiates the block with FREE_INIT just below the 32-bit boundary, reads the low word a few ticks before the carry, ticks past it and confirms that the high word read returns the pre-carry snapshot. The same-cycle expiry and acknowledge race is reached by holding tick_en and an acknowledge write together in the cycle where the counter runs out.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int DATA_W  = 32;
  localparam int EV_W    = 56;
  localparam int FREE_W  = 64;
  localparam int ADDR_W  = 8;
  localparam int EV_HI_W = EV_W - DATA_W;

  localparam logic [ADDR_W-1:0] OFS_RELOAD_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL      = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_FREE_LO   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_FREE_HI   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_MASK_SET  = 8'h2c;
  localparam logic [ADDR_W-1:0] OFS_MASK_CLR  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_ACK       = 8'h34;

  localparam int CTL_EN_BIT   = 24;
  localparam int CTL_REP_BIT  = 28;
  localparam int CTL_LOAD_BIT = 30;

  // The count is at its last step when one (or zero) remains.
  function automatic logic ev_at_end(input logic [EV_W-1:0] cnt);
    return cnt <= EV_W'(1);
  endfunction

  // Next value of the down-counter on a tick.
  function automatic logic [EV_W-1:0] ev_step(input logic [EV_W-1:0] cnt,
                                              input logic [EV_W-1:0] reload,
                                              input logic            periodic);
    if (ev_at_end(cnt)) return periodic ? reload : '0;
    return cnt - EV_W'(1);
  endfunction

  function automatic logic [FREE_W-1:0] free_step(input logic [FREE_W-1:0] cnt);
    return cnt + FREE_W'(1);
  endfunction
endpackage

// File: rtl/dtmr_event_timer.sv
module dtmr_event_timer
  import dtmr_pkg::*;
#(
  parameter int EVW = EV_W,
  parameter int DW  = DATA_W,
  localparam int HW = EVW - DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           lo_wr,
  input  logic [DW-1:0]  lo_data,
  input  logic           ctrl_wr,
  input  logic [HW-1:0]  ctrl_hi,
  input  logic           ctrl_en,
  input  logic           ctrl_rep,
  input  logic           ctrl_load,
  output logic [EVW-1:0] reload_q,
  output logic           ev_en,
  output logic           ev_periodic,
  output logic [EVW-1:0] ev_count,
  output logic           expire_ev
);
  // A control write takes the cycle; no count step happens alongside it.
  assign expire_ev = ev_en & tick_en & ~ctrl_wr & ev_at_end(ev_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q    <= '0;
      ev_en       <= 1'b0;
      ev_periodic <= 1'b0;
      ev_count    <= '0;
    end else begin
      if (lo_wr) reload_q[DW-1:0] <= lo_data;
      if (ctrl_wr) begin
        reload_q[EVW-1:DW] <= ctrl_hi;
        ev_en              <= ctrl_en;
        ev_periodic        <= ctrl_rep;
        if (ctrl_load) ev_count <= {ctrl_hi, reload_q[DW-1:0]};
      end else if (ev_en && tick_en) begin
        ev_count <= ev_step(ev_count, reload_q, ev_periodic);
        if (expire_ev && !ev_periodic) ev_en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dtmr_free_counter.sv
module dtmr_free_counter
  import dtmr_pkg::*;
#(
  parameter int FW = FREE_W,
  parameter int DW = DATA_W,
  parameter logic [FW-1:0] INIT = '0,
  localparam int UW = FW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          snap,
  output logic [FW-1:0] free_cnt,
  output logic [UW-1:0] hi_hold
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_cnt <= INIT;
      hi_hold  <= '0;
    end else begin
      if (tick_en) free_cnt <= free_step(free_cnt);
      // Snapshot the upper half seen by the same cycle as the low-word read.
      if (snap) hi_hold <= free_cnt[FW-1:DW];
    end
  end
endmodule

// File: rtl/dtmr_irq_ctrl.sv
module dtmr_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic ack_ev,
  input  logic expire_ev,
  output logic mask_q,
  output logic pending_q,
  output logic irq_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      if (mask_set)      mask_q <= 1'b1;
      else if (mask_clr) mask_q <= 1'b0;
      if (expire_ev)     pending_q <= 1'b1;
      else if (ack_ev)   pending_q <= 1'b0;
    end
  end

  assign irq_out = pending_q & mask_q;
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
  import dtmr_pkg::*;
#(
  parameter logic [FREE_W-1:0] FREE_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int UW = FREE_W - DATA_W;

  logic              lo_wr, ctrl_wr, mask_set, mask_clr, ack_ev, snap;
  logic [EV_W-1:0]   reload_q, ev_count;
  logic              ev_en, ev_periodic, expire_ev;
  logic              mask_q, pending_q;
  logic [FREE_W-1:0] free_cnt;
  logic [UW-1:0]     hi_hold;

  assign lo_wr    = bus_we && (bus_addr == OFS_RELOAD_LO);
  assign ctrl_wr  = bus_we && (bus_addr == OFS_CTRL);
  assign mask_set = bus_we && (bus_addr == OFS_MASK_SET) && bus_wdata[0];
  assign mask_clr = bus_we && (bus_addr == OFS_MASK_CLR) && bus_wdata[0];
  assign ack_ev   = bus_we && (bus_addr == OFS_ACK) && bus_wdata[0];
  assign snap     = bus_re && (bus_addr == OFS_FREE_LO);

  dtmr_event_timer #(.EVW(EV_W), .DW(DATA_W)) u_event (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .lo_wr      (lo_wr),
    .lo_data    (bus_wdata),
    .ctrl_wr    (ctrl_wr),
    .ctrl_hi    (bus_wdata[EV_HI_W-1:0]),
    .ctrl_en    (bus_wdata[CTL_EN_BIT]),
    .ctrl_rep   (bus_wdata[CTL_REP_BIT]),
    .ctrl_load  (bus_wdata[CTL_LOAD_BIT]),
    .reload_q   (reload_q),
    .ev_en      (ev_en),
    .ev_periodic(ev_periodic),
    .ev_count   (ev_count),
    .expire_ev  (expire_ev)
  );

  dtmr_free_counter #(.FW(FREE_W), .DW(DATA_W), .INIT(FREE_INIT)) u_free (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .snap    (snap),
    .free_cnt(free_cnt),
    .hi_hold (hi_hold)
  );

  dtmr_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .ack_ev   (ack_ev),
    .expire_ev(expire_ev),
    .mask_q   (mask_q),
    .pending_q(pending_q),
    .irq_out  (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_RELOAD_LO: bus_rdata = reload_q[DATA_W-1:0];
      OFS_CTRL: begin
        bus_rdata[EV_HI_W-1:0]  = reload_q[EV_W-1:DATA_W];
        bus_rdata[CTL_EN_BIT]   = ev_en;
        bus_rdata[CTL_REP_BIT]  = ev_periodic;
      end
      OFS_FREE_LO:  bus_rdata = free_cnt[DATA_W-1:0];
      OFS_FREE_HI:  bus_rdata = DATA_W'(hi_hold);
      OFS_MASK_SET: bus_rdata[0] = mask_q;
      OFS_ACK:      bus_rdata[0] = pending_q;
      default:      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        ctrl_wr,
  input logic        ack_ev,
  input logic        expire_ev,
  input logic        ev_en,
  input logic        ev_periodic,
  input logic [55:0] ev_count,
  input logic        mask_q,
  input logic        pending_q,
  input logic        irq_out,
  input logic [63:0] free_cnt
);
  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> mask_q);
  a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> pending_q);
  a_r10_expire_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    expire_ev |=> pending_q);
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && !expire_ev) |=> !pending_q);
  a_r3_single_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_ev && !ev_periodic) |=> !ev_en);
  a_r4_repeat_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_ev && ev_periodic) |=> ev_en);
  a_r6_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ctrl_wr) |=> $stable(ev_count));
  a_r11_free_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (free_cnt == $past(free_cnt) + 64'd1));
  a_r6_free_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(free_cnt));
endmodule

bind dtmr_top dtmr_checker u_dtmr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .ctrl_wr    (ctrl_wr),
  .ack_ev     (ack_ev),
  .expire_ev  (expire_ev),
  .ev_en      (ev_en),
  .ev_periodic(ev_periodic),
  .ev_count   (ev_count),
  .mask_q     (mask_q),
  .pending_q  (pending_q),
  .irq_out    (irq_out),
  .free_cnt   (free_cnt)
);

// File: tb/dtmr_top_bench.sv
module dtmr_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] INIT_VAL = 64'h0000_0000_FFFF_FFF0;
  localparam logic [31:0] LOAD = 32'h4000_0000;
  localparam logic [31:0] EN   = 32'h0100_0000;
  localparam logic [31:0] REP  = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtmr_top #(.FREE_INIT(INIT_VAL)) u_dtmr_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic pend_is(input string tag, input logic exp);
    logic [31:0] d;
    rd(8'h34, d);
    chk(tag, {63'd0, d[0]}, {63'd0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq after reset", {63'd0, irq_out}, 64'd0);
    rd(8'h04, d); chk("R1 control after reset", {32'd0, d}, 64'd0);
    rd(8'h2c, d); chk("R1 mask after reset", {32'd0, d}, 64'd0);
    pend_is("R1 pending after reset", 1'b0);
    rd(8'h24, d); chk("R1 free counter init", {32'd0, d}, {32'd0, INIT_VAL[31:0]});
  endtask

  task automatic t_free;
    logic [31:0] d;
    ticks(14);
    rd(8'h24, d); chk("R11 low word after 14 ticks", {32'd0, d}, 64'h0000_0000_FFFF_FFFE);
    ticks(5);
    rd(8'h28, d); chk("R12 high word is pre-carry snapshot", {32'd0, d}, 64'd0);
    rd(8'h24, d); chk("R11 low word after carry", {32'd0, d}, 64'd3);
    rd(8'h28, d); chk("R12 high word after carry", {32'd0, d}, 64'd1);
  endtask

  task automatic t_single;
    logic [31:0] d;
    wr(8'h2c, 32'h1);
    wr(8'h00, 32'd5);
    wr(8'h04, LOAD | EN);
    ticks(4);
    pend_is("R2 no expiry before Nth tick", 1'b0);
    chk("R8 irq low while not pending", {63'd0, irq_out}, 64'd0);
    ticks(1);
    chk("R2 R8 irq at Nth tick", {63'd0, irq_out}, 64'd1);
    rd(8'h04, d); chk("R3 enable cleared after single expiry", {63'd0, d[24]}, 64'd0);
    wr(8'h34, 32'h1);
    chk("R9 ack drops irq", {63'd0, irq_out}, 64'd0);
    ticks(10);
    pend_is("R3 no further expiry", 1'b0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(8'h30, 32'h1);
    rd(8'h2c, d); chk("R7 mask cleared", {63'd0, d[0]}, 64'd0);
    wr(8'h00, 32'd2);
    wr(8'h04, LOAD | EN);
    ticks(2);
    pend_is("R2 pending while masked", 1'b1);
    chk("R8 irq held low by mask", {63'd0, irq_out}, 64'd0);
    wr(8'h2c, 32'hFFFF_FFFE);
    rd(8'h2c, d); chk("R7 zero bit 0 set write ignored", {63'd0, d[0]}, 64'd0);
    wr(8'h2c, 32'h1);
    chk("R8 irq once mask set", {63'd0, irq_out}, 64'd1);
    wr(8'h30, 32'h0);
    chk("R7 zero bit 0 clear write ignored", {63'd0, irq_out}, 64'd1);
    wr(8'h34, 32'h0);
    pend_is("R9 zero bit 0 ack ignored", 1'b1);
    wr(8'h30, 32'h1);
    chk("R7 R8 irq low after mask clear", {63'd0, irq_out}, 64'd0);
    wr(8'h34, 32'h1);
    pend_is("R9 ack clears pending", 1'b0);
    wr(8'h2c, 32'h1);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    wr(8'h00, 32'd3);
    wr(8'h04, LOAD | EN | REP);
    ticks(3);
    pend_is("R4 first period expiry", 1'b1);
    wr(8'h34, 32'h1);
    ticks(2);
    pend_is("R4 mid second period", 1'b0);
    ticks(1);
    pend_is("R4 second period expiry", 1'b1);
    rd(8'h04, d); chk("R4 enable and repeat kept", {62'd0, d[28], d[24]}, 64'd3);
    wr(8'h34, 32'h1);
  endtask

  task automatic t_stop;
    wr(8'h04, 32'h0);
    wr(8'h34, 32'h1);
    ticks(10);
    pend_is("R5 stopped timer never expires", 1'b0);
  endtask

  task automatic t_gate;
    wr(8'h00, 32'd2);
    wr(8'h04, LOAD | EN);
    repeat (20) @(negedge clk);
    pend_is("R6 no count without tick", 1'b0);
    ticks(2);
    pend_is("R6 counts once ticks arrive", 1'b1);
    wr(8'h34, 32'h1);
  endtask

  task automatic t_race;
    wr(8'h00, 32'd2);
    wr(8'h04, LOAD | EN);
    ticks(1);
    @(negedge clk);
    tick_en = 1'b1; bus_addr = 8'h34; bus_wdata = 32'h1; bus_we = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    pend_is("R10 expiry wins over ack", 1'b1);
    wr(8'h34, 32'h1);
    pend_is("R9 later ack clears", 1'b0);
  endtask

  task automatic t_wide;
    logic [31:0] d;
    wr(8'h00, 32'h0000_0010);
    wr(8'h04, LOAD | EN | 32'h0000_0001);
    rd(8'h00, d); chk("R13 reload low readback", {32'd0, d}, 64'h10);
    rd(8'h04, d); chk("R13 reload high readback", {40'd0, d[23:0]}, 64'd1);
    ticks(40);
    pend_is("R13 upper reload bits lengthen count", 1'b0);
    wr(8'h04, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_free();
    t_single();
    t_mask();
    t_periodic();
    t_stop();
    t_gate();
    t_race();
    t_wide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule